// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral on a small synchronous register bus. It has three 16-bit registers: control, service and cause. Software sets a timeout in half-second units and then turns the watchdog on. From then on, software must keep feeding it a two-word key pair through the service register. If the count runs out before a complete pair arrives, the block raises a reset request for a fixed number of clock cycles. It also records that the watchdog caused the reset.

The half-second tick is made from an external timebase strobe by a prescaler. A parameter sets how many strobes make one tick, so the same block runs with a short period in simulation. Two freeze flags in the control register let the count pause while a debug-halt input or a low-power input is high. Once enabled, the watchdog cannot be switched off by software. A changed timeout value takes effect only at the next reload.

Top module: `svc_watchdog`

## Requirements
- R1: The registers sit at byte offsets 0 (control), 2 (service) and 4 (cause). `bus_rdata` returns the addressed register in the same cycle. Other offsets read 0. The service register reads 0. The cause register cannot be written.
- R2: After `rst_n` the control register reads 0x0000 and the cause register reads 0x0001 (bit 0 means power-on cause). `wd_reset_out` is low. While disabled, no number of strobes raises `wd_reset_out`.
- R3: Writing control with bit 2 set turns the watchdog on and loads timeout field WT (bits 15:8, written in the same access). Expiry comes on the (WT+1)×STROBES_PER_TICK-th accepted strobe after that load.
- R4: The count reloads only when the service register receives 0x5555 and then 0xAAAA. A service write of 0x5555 always arms the sequence. Any other service write (0xAAAA unarmed, or any other value) disarms it and reloads nothing.
- R5: The enable bit is write-once. Writing 0 to bit 2 after it is set leaves it set.
- R6: A WT written while the watchdog runs does not change the count in progress. It is used at the next reload, either from a service pair or from the automatic reload on expiry.
- R7: On expiry, `wd_reset_out` is high for exactly RST_HOLD_CYCLES cycles. The cause register reads 0x0002 (bit 1 means timeout cause). The count reloads with WT and keeps running.
- R8: With control bit 1 set, strobes are ignored while `dbg_halt` is high. With bit 1 clear, `dbg_halt` has no effect.
- R9: With control bit 0 set, strobes are ignored while `lp_mode` is high.
- R10: Each load (enable or service pair) also clears the partial strobe count of the prescaler.
- R11: Control bits 7, 4 and 3 are plain stored flags that read back as written. Bits 6:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| time_strobe | input | 1 | Timebase strobe, one cycle wide |
| dbg_halt | input | 1 | Debug-halt state, gates counting when enabled |
| lp_mode | input | 1 | Low-power state, gates counting when enabled |
| wd_reset_out | output | 1 | Reset request on expiry |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` one time unit after it sets the address at a falling edge. Writes and strobes are driven at a falling edge and are taken at the next rising edge. `wd_reset_out` rises on the rising edge that samples the final strobe, so the bench checks it at the falling edge right after that strobe. The bench also checks it one strobe earlier and expects it low there. The hold length is counted as the number of falling edges at which the output is high.

// File: rtl/svcwd_pkg.sv
package svcwd_pkg;

  localparam logic [15:0] KEY_ARM    = 16'h5555;
  localparam logic [15:0] KEY_FIRE   = 16'hAAAA;
  localparam logic [2:0]  OFS_CTRL   = 3'd0;
  localparam logic [2:0]  OFS_SVC    = 3'd2;
  localparam logic [2:0]  OFS_CAUSE  = 3'd4;

  typedef struct packed {
    logic [7:0] wt;
    logic       flag7;
    logic [1:0] rsv;
    logic       flag4;
    logic       flag3;
    logic       en;
    logic       dbg_frz;
    logic       lp_frz;
  } ctrl_t;

  // number of half-second ticks a timeout value spans
  function automatic int unsigned ticks_for(input logic [7:0] wt);
    return int'(wt) + 1;
  endfunction

  // control word as presented on the bus
  function automatic logic [15:0] ctrl_view(input ctrl_t c);
    ctrl_t v;
    v     = c;
    v.rsv = 2'b00;
    return v;
  endfunction

endpackage

// File: rtl/svcwd_prescale.sv
module svcwd_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic strobe,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && strobe && !clear && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (clear)            pre_q <= '0;
    else if (run && strobe)    pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
  end

  // R8/R9: a frozen or disabled prescaler keeps its partial count
  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(pre_q));

  // R10: a load empties the partial count
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0));

endmodule

// File: rtl/svcwd_keyseq.sv
module svcwd_keyseq
  import svcwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_we,
  input  logic [15:0] svc_data,
  output logic        reload_req
);
  logic armed_q;

  assign reload_req = svc_we && (svc_data == KEY_FIRE) && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (svc_we)  armed_q <= (svc_data == KEY_ARM);
  end

  // R4: any service write other than the arming key leaves it disarmed
  a_r4_stray_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && svc_data != KEY_ARM) |=> !armed_q);

  // R4: arming only follows a write of the first key
  a_r4_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_we && svc_data == KEY_ARM));

endmodule

// File: rtl/svcwd_count.sv
module svcwd_count #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (tick)  cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
  end

  // R3: a load places the timeout value in the counter
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R3: each tick away from zero takes exactly one step
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/svcwd_rsthold.sv
module svcwd_rsthold #(
  parameter int unsigned HOLD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_out
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_out <= 1'b0;
      left_q  <= '0;
    end else if (fire) begin
      rst_out <= 1'b1;
      left_q  <= HW'(HOLD - 1);
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end else begin
      rst_out <= 1'b0;
    end
  end

  // R7: an expiry raises the request on the next edge
  a_r7_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_out);

  // R7: the request never drops while hold cycles remain
  a_r7_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out && left_q != '0) |=> rst_out);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svcwd_pkg::*;
#(
  parameter int unsigned STROBES_PER_TICK = 16,
  parameter int unsigned RST_HOLD_CYCLES  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        time_strobe,
  input  logic        dbg_halt,
  input  logic        lp_mode,
  output logic        wd_reset_out
);
  ctrl_t       ctrl_q;
  logic [1:0]  cause_q;   // bit1 timeout, bit0 power-on

  // named internal events
  logic        wr_ctrl, wr_svc;
  logic        enable_now, reload_req, load, tick, expire;
  logic        frozen, run;
  logic [7:0]  load_wt;
  logic        unused_rsv;

  assign unused_rsv = ^bus_wdata[6:5];

  assign wr_ctrl    = bus_we && (bus_addr == OFS_CTRL);
  assign wr_svc     = bus_we && (bus_addr == OFS_SVC);
  assign enable_now = wr_ctrl && bus_wdata[2] && !ctrl_q.en;
  assign load       = enable_now || (reload_req && ctrl_q.en);
  assign load_wt    = enable_now ? bus_wdata[15:8] : ctrl_q.wt;
  assign frozen     = (ctrl_q.dbg_frz && dbg_halt) || (ctrl_q.lp_frz && lp_mode);
  assign run        = ctrl_q.en && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.wt      <= bus_wdata[15:8];
      ctrl_q.flag7   <= bus_wdata[7];
      ctrl_q.rsv     <= 2'b00;
      ctrl_q.flag4   <= bus_wdata[4];
      ctrl_q.flag3   <= bus_wdata[3];
      ctrl_q.en      <= ctrl_q.en | bus_wdata[2];
      ctrl_q.dbg_frz <= bus_wdata[1];
      ctrl_q.lp_frz  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_q <= 2'b01;
    else if (expire) cause_q <= 2'b10;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_view(ctrl_q);
      OFS_CAUSE: bus_rdata = {14'd0, cause_q};
      default:   bus_rdata = 16'd0;
    endcase
  end

  svcwd_keyseq u_keyseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .svc_we     (wr_svc),
    .svc_data   (bus_wdata),
    .reload_req (reload_req)
  );

  svcwd_prescale #(.DIV(STROBES_PER_TICK)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load),
    .run    (run),
    .strobe (time_strobe),
    .tick   (tick)
  );

  svcwd_count #(.CW(8)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_wt),
    .tick     (tick),
    .expire   (expire)
  );

  svcwd_rsthold #(.HOLD(RST_HOLD_CYCLES)) u_rsthold (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (expire),
    .rst_out (wd_reset_out)
  );

  // R5: enable stays set once written
  a_r5_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ctrl_q.en);

  // R2: a disabled watchdog never expires
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !expire);

  // R7: expiry records the timeout cause
  a_r7_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cause_q == 2'b10));

  // R4: a reload is only honoured while enabled and clears the prescaler
  a_r4_load_gate: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tick);

endmodule

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb;
  localparam int unsigned DIV  = 4;
  localparam int unsigned HOLD = 8;
  localparam logic [7:0] VEC_WT [4] = '{8'd0, 8'd2, 8'd1, 8'd4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        time_strobe = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        lp_mode = 1'b0;
  logic        wd_reset_out;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  svc_watchdog #(.STROBES_PER_TICK(DIV), .RST_HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_strobe(time_strobe),
    .dbg_halt(dbg_halt), .lp_mode(lp_mode), .wd_reset_out(wd_reset_out)
  );

  function automatic int unsigned strobes_to_expire(input logic [7:0] wt);
    return (int'(wt) + 1) * DIV;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic strobes(input int unsigned n);
    for (int i = 0; i < int'(n); i++) begin
      @(negedge clk); time_strobe = 1'b1;
      @(negedge clk); time_strobe = 1'b0;
    end
    #1;
  endtask

  task automatic service();
    wr(3'd2, 16'h5555);
    wr(3'd2, 16'hAAAA);
  endtask

  task automatic hold_check(input string req);
    int unsigned high = 0;
    while (wd_reset_out === 1'b1 && high < 100) begin
      high++;
      @(negedge clk); #1;
    end
    chk(req, 16'(high), 16'(HOLD));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(3'd0, v); chk("R2 ctrl after reset", v, 16'h0000);
    rd(3'd4, v); chk("R2 cause after reset", v, 16'h0001);
    chk("R2 reset out low", {15'd0, wd_reset_out}, 16'h0000);
    strobes(40);
    chk("R2 disabled never fires", {15'd0, wd_reset_out}, 16'h0000);

    // R1 / R11 register map and stored flags
    wr(3'd0, 16'h0398);
    rd(3'd0, v); chk("R11 flags read back", v, 16'h0398);
    wr(3'd0, 16'h0360);
    rd(3'd0, v); chk("R11 bits 6:5 read zero", v, 16'h0300);
    rd(3'd6, v); chk("R1 unmapped reads zero", v, 16'h0000);
    rd(3'd2, v); chk("R1 service reads zero", v, 16'h0000);
    wr(3'd4, 16'h0000);
    rd(3'd4, v); chk("R1 cause not writable", v, 16'h0001);

    // R3 / R7 table walk
    foreach (VEC_WT[k]) begin
      wr(3'd0, {VEC_WT[k], 8'h04});
      service();
      strobes(strobes_to_expire(VEC_WT[k]) - 1);
      chk("R3 no expiry one strobe early", {15'd0, wd_reset_out}, 16'h0000);
      strobes(1);
      chk("R3 expiry on last strobe", {15'd0, wd_reset_out}, 16'h0001);
      hold_check("R7 hold length");
      rd(3'd4, v); chk("R7 timeout cause", v, 16'h0002);
    end

    // R5 write-once enable
    wr(3'd0, 16'h0100);
    rd(3'd0, v); chk("R5 enable sticks", v, 16'h0104);

    // R6 timeout change waits for reload
    service();
    wr(3'd0, 16'h0004);
    strobes(7);
    chk("R6 old timeout still running", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R6 expiry at old timeout", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold after R6");
    strobes(3);
    chk("R6 auto reload uses new value early", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R6 auto reload uses new value", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold auto reload");

    // R4 broken sequence does not reload
    wr(3'd0, 16'h0104);
    service();
    strobes(6);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
    strobes(1);
    chk("R4 broken pair pre", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R4 broken pair no reload", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold R4a");

    service();
    strobes(6);
    wr(3'd2, 16'hAAAA);
    strobes(1);
    chk("R4 lone second key pre", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R4 lone second key no reload", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold R4b");

    // R4 repeated arm key then fire key reloads; R10 prescaler cleared
    service();
    strobes(6);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    strobes(7);
    chk("R10 R4 reload restarts full period", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R10 expiry after full period", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold R10");

    // R8 debug freeze
    wr(3'd0, 16'h0106);
    service();
    dbg_halt = 1'b1;
    strobes(20);
    chk("R8 frozen under debug", {15'd0, wd_reset_out}, 16'h0000);
    dbg_halt = 1'b0;
    strobes(7);
    chk("R8 resumes count pre", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R8 resumes count", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold R8");

    wr(3'd0, 16'h0104);
    service();
    dbg_halt = 1'b1;
    strobes(7);
    chk("R8 flag clear no freeze pre", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R8 flag clear no freeze", {15'd0, wd_reset_out}, 16'h0001);
    dbg_halt = 1'b0;
    hold_check("R7 hold R8b");

    // R9 low-power freeze
    wr(3'd0, 16'h0105);
    service();
    lp_mode = 1'b1;
    strobes(20);
    chk("R9 frozen in low power", {15'd0, wd_reset_out}, 16'h0000);
    lp_mode = 1'b0;
    strobes(7);
    chk("R9 resumes pre", {15'd0, wd_reset_out}, 16'h0000);
    strobes(1);
    chk("R9 resumes", {15'd0, wd_reset_out}, 16'h0001);
    hold_check("R7 hold R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule